// File: doc/BRIEF.md
# Debug Bus-Match Comparator Channel

This block is a single channel of an on-chip debug comparator. Each cycle it looks at one of two processor buses, chosen by a source-select control bit. It compares the bus address against a programmed value, and it can also check the access direction and the access size. What happens on a match depends on the channel mode. In immediate mode a match raises a trigger in the next cycle. In tagged mode a match on an opcode fetch marks that opcode inside a small shadow of the instruction queue. The trigger fires only when the marked opcode leaves the queue toward execution. A queue flush discards every mark, so an opcode that is thrown away never triggers.

A per-channel break control turns each trigger into an immediate breakpoint request, which bypasses any sequencing logic. This needs a global break permission that is nonzero. The same request also raises a disarm pulse, which stops tracing and disarms the debug logic around the channel. The sequencer, the trace storage and register access sit outside this block. They connect to its trigger, break and disarm outputs.

Top module: `dbg_match_chan`

## Requirements
- R1: While `cfg_en` is 0 in a cycle, that cycle causes no trigger, no break request and no tag is recorded.
- R2: `cfg_src` = 0 compares the CPU bus (`cpu_*`) and `cfg_src` = 1 compares the coprocessor bus (`cop_*`). The unselected bus has no effect.
- R3: With `cfg_tag` = 0, a valid access whose address equals `cfg_addr` over its full width, and which passes R4 and R5, drives `trig_o` high in the following cycle.
- R4: With `cfg_rwe` = 0 the direction is ignored. With `cfg_rwe` = 1 and `cfg_rw` = 0, only writes (`*_rd` = 0) match. With `cfg_rw` = 1, only reads (`*_rd` = 1) match.
- R5: With `cfg_sze` = 1, `cfg_sz` = 0 matches only word accesses (`*_byte` = 0) and `cfg_sz` = 1 matches only byte accesses (`*_byte` = 1). With `cfg_sze` = 0 the size is ignored.
- R6: With `cfg_tag` = 1, only opcode fetches (`*_fetch` = 1) on an advance cycle (`q_adv` = 1) can be tagged. Direction, size, `cfg_rwe`, `cfg_rw`, `cfg_sze` and `cfg_sz` are ignored, and no immediate trigger occurs.
- R7: A tagged opcode executes on the DEPTH-th advance after the advance that fetched it. `trig_o` goes high in the cycle after that advance, provided `cfg_en` and `cfg_tag` are still 1. Cycles without an advance do not move the tag.
- R8: `q_flush` = 1 clears all tags and takes priority over `q_adv`, so no tagged trigger occurs in the flush cycle or from any opcode held before it.
- R9: `brk_o` and `disarm_o` are high exactly when `trig_o` is high, `cfg_brk` was 1 and `brk_gen_en` was nonzero in the cycle that caused the trigger.
- R10: All outputs are 0 after reset, and each event gives `trig_o` high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Channel enable |
| cfg_src | input | 1 | Bus select: 0 CPU, 1 coprocessor |
| cfg_tag | input | 1 | 1 selects tagged mode |
| cfg_brk | input | 1 | Immediate break on trigger |
| cfg_rwe | input | 1 | Direction compare enable |
| cfg_rw | input | 1 | Direction to match: 1 read, 0 write |
| cfg_sze | input | 1 | Size compare enable |
| cfg_sz | input | 1 | Size to match: 1 byte, 0 word |
| cfg_addr | input | ADDR_W | Programmed match address |
| brk_gen_en | input | 2 | Global break permission, nonzero allows |
| cpu_valid | input | 1 | CPU bus access valid |
| cpu_addr | input | ADDR_W | CPU bus address |
| cpu_rd | input | 1 | CPU access is a read |
| cpu_byte | input | 1 | CPU access is byte sized |
| cpu_fetch | input | 1 | CPU access is an opcode fetch |
| cop_valid | input | 1 | Coprocessor bus access valid |
| cop_addr | input | ADDR_W | Coprocessor bus address |
| cop_rd | input | 1 | Coprocessor access is a read |
| cop_byte | input | 1 | Coprocessor access is byte sized |
| cop_fetch | input | 1 | Coprocessor access is an opcode fetch |
| q_adv | input | 1 | Instruction queue advances this cycle |
| q_flush | input | 1 | Instruction queue is flushed this cycle |
| trig_o | output | 1 | Trigger pulse |
| brk_o | output | 1 | Immediate breakpoint request |
| disarm_o | output | 1 | Stop trace and disarm request |

## Verification
The assertions check these rules on every cycle: a disabled channel never triggers, a tag hit needs an opcode fetch, a tagged execute needs an advance, a flush leaves nothing to execute in the next cycle, and a break or disarm never appears without a trigger and a nonzero global permission. Several rules can only be shown by the bench's scenarios. These are the exact advance count before a tagged trigger, stalls that hold a tag in place, a flush that removes a tag fetched several advances earlier, the bus-select and direction/size truth tables, and the full-width address compare. The bench covers them with directed sequences and a long random run against its queue-based model.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

  typedef struct packed {
    logic valid;
    logic rd;
    logic byte_acc;
    logic fetch;
  } bus_attr_t;

  typedef struct packed {
    logic en;
    logic src;
    logic tag;
    logic brk;
    logic rwe;
    logic rw;
    logic sze;
    logic sz;
  } chan_cfg_t;

  // Direction qualifier: passes when direction compare is off, or when the
  // access direction equals the programmed one.
  function automatic logic dir_ok(input logic rwe, input logic rw, input logic rd);
    logic r;
    if (!rwe) r = 1'b1;
    else      r = (rw == rd);
    return r;
  endfunction

  // Size qualifier: passes when size compare is off, or when sizes agree.
  function automatic logic size_ok(input logic sze, input logic sz, input logic byte_acc);
    logic r;
    if (!sze) r = 1'b1;
    else      r = (sz == byte_acc);
    return r;
  endfunction

endpackage

// File: rtl/dbg_bus_sel.sv
module dbg_bus_sel
  import dbg_match_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  bus_attr_t         cpu_attr,
  input  logic [ADDR_W-1:0] cop_addr,
  input  bus_attr_t         cop_attr,
  output logic [ADDR_W-1:0] sel_addr,
  output bus_attr_t         sel_attr
);

  always_comb begin
    if (src) begin
      sel_addr = cop_addr;
      sel_attr = cop_attr;
    end else begin
      sel_addr = cpu_addr;
      sel_attr = cpu_attr;
    end
  end

  // R2: a valid selected access must come from the chosen bus
  assert_src_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!src && sel_attr.valid) |-> cpu_attr.valid);
  assert_src_cop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src && sel_attr.valid) |-> cop_attr.valid);

endmodule

// File: rtl/dbg_match_core.sv
module dbg_match_core
  import dbg_match_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cfg_t         cfg,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] sel_addr,
  input  bus_attr_t         sel_attr,
  output logic              imm_hit,
  output logic              tag_hit
);

  logic addr_eq;
  logic qual_ok;
  logic armed;

  assign addr_eq = (sel_addr == cfg_addr);
  assign armed   = cfg.en && sel_attr.valid && addr_eq;
  assign qual_ok = dir_ok(cfg.rwe, cfg.rw, sel_attr.rd) &&
                   size_ok(cfg.sze, cfg.sz, sel_attr.byte_acc);

  // Immediate mode: qualified by direction and size.
  assign imm_hit = armed && !cfg.tag && qual_ok;
  // Tagged mode: only opcode fetches, direction and size ignored.
  assign tag_hit = armed && cfg.tag && sel_attr.fetch;

  // R6: a tag is only raised by an opcode fetch
  assert_tag_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tag_hit |-> (sel_attr.fetch && cfg.tag));
  // R3: immediate and tagged hits never coexist
  assert_mode_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(imm_hit && tag_hit));
  // R1: nothing matches while disabled
  assert_off_nohit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> !(imm_hit || tag_hit));

endmodule

// File: rtl/dbg_tag_queue.sv
module dbg_tag_queue #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic flush,
  input  logic tag_in,
  output logic exec_tag
);

  logic [DEPTH-1:0] slot_q;

  // Slot 0 receives the opcode fetched on an advance; the last slot issues.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     slot_q[0] <= 1'b0;
    else if (flush) slot_q[0] <= 1'b0;
    else if (adv)   slot_q[0] <= tag_in;
  end

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     slot_q[i] <= 1'b0;
        else if (flush) slot_q[i] <= 1'b0;
        else if (adv)   slot_q[i] <= slot_q[i-1];
      end
    end
  endgenerate

  assign exec_tag = adv && !flush && slot_q[DEPTH-1];

  // R8: after a flush no tag is left to execute
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !exec_tag);
  // R7: a tag reaches execution only on an advance
  assert_exec_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_tag |-> adv);

endmodule

// File: rtl/dbg_match_chan.sv
module dbg_match_chan
  import dbg_match_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_src,
  input  logic              cfg_tag,
  input  logic              cfg_brk,
  input  logic              cfg_rwe,
  input  logic              cfg_rw,
  input  logic              cfg_sze,
  input  logic              cfg_sz,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        brk_gen_en,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_byte,
  input  logic              cpu_fetch,
  input  logic              cop_valid,
  input  logic [ADDR_W-1:0] cop_addr,
  input  logic              cop_rd,
  input  logic              cop_byte,
  input  logic              cop_fetch,
  input  logic              q_adv,
  input  logic              q_flush,
  output logic              trig_o,
  output logic              brk_o,
  output logic              disarm_o
);

  chan_cfg_t         cfg;
  bus_attr_t         cpu_attr, cop_attr, sel_attr;
  logic [ADDR_W-1:0] sel_addr;
  logic              imm_hit, tag_hit, exec_tag;
  logic              tag_push, exec_trig, trig_d, brk_d;
  logic              trig_q, brk_q;

  assign cfg      = '{en: cfg_en, src: cfg_src, tag: cfg_tag, brk: cfg_brk,
                      rwe: cfg_rwe, rw: cfg_rw, sze: cfg_sze, sz: cfg_sz};
  assign cpu_attr = '{valid: cpu_valid, rd: cpu_rd, byte_acc: cpu_byte, fetch: cpu_fetch};
  assign cop_attr = '{valid: cop_valid, rd: cop_rd, byte_acc: cop_byte, fetch: cop_fetch};

  dbg_bus_sel #(.ADDR_W(ADDR_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (cfg.src),
    .cpu_addr (cpu_addr),
    .cpu_attr (cpu_attr),
    .cop_addr (cop_addr),
    .cop_attr (cop_attr),
    .sel_addr (sel_addr),
    .sel_attr (sel_attr)
  );

  dbg_match_core #(.ADDR_W(ADDR_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .cfg_addr (cfg_addr),
    .sel_addr (sel_addr),
    .sel_attr (sel_attr),
    .imm_hit  (imm_hit),
    .tag_hit  (tag_hit)
  );

  assign tag_push = tag_hit && q_adv;

  dbg_tag_queue #(.DEPTH(DEPTH)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (q_adv),
    .flush    (q_flush),
    .tag_in   (tag_push),
    .exec_tag (exec_tag)
  );

  assign exec_trig = cfg.en && cfg.tag && exec_tag;
  assign trig_d    = imm_hit || exec_trig;
  assign brk_d     = trig_d && cfg.brk && (brk_gen_en != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      trig_q <= trig_d;
      brk_q  <= brk_d;
    end
  end

  assign trig_o   = trig_q;
  assign brk_o    = brk_q;
  assign disarm_o = brk_q;

  // R1: a disabled cycle yields no trigger in the next one
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !trig_o);
  // R9: break only alongside a trigger and with global permission
  assert_brk_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> (trig_o && disarm_o));
  assert_brk_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_gen_en == 2'b00) |=> !brk_o);

endmodule

// File: tb/dbg_match_chan_bench.sv
module dbg_match_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 23;
  localparam int DEPTH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en, cfg_src, cfg_tag, cfg_brk, cfg_rwe, cfg_rw, cfg_sze, cfg_sz;
  logic [AW-1:0] cfg_addr;
  logic [1:0] brk_gen_en;
  logic cpu_valid, cpu_rd, cpu_byte, cpu_fetch;
  logic [AW-1:0] cpu_addr;
  logic cop_valid, cop_rd, cop_byte, cop_fetch;
  logic [AW-1:0] cop_addr;
  logic q_adv, q_flush;
  logic trig_o, brk_o, disarm_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";
  bit mq[$];
  bit saw_trig;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_match_chan #(.ADDR_W(AW), .DEPTH(DEPTH)) u_dbg_match_chan (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_en), .cfg_src(cfg_src), .cfg_tag(cfg_tag), .cfg_brk(cfg_brk),
    .cfg_rwe(cfg_rwe), .cfg_rw(cfg_rw), .cfg_sze(cfg_sze), .cfg_sz(cfg_sz),
    .cfg_addr(cfg_addr), .brk_gen_en(brk_gen_en),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_byte(cpu_byte), .cpu_fetch(cpu_fetch),
    .cop_valid(cop_valid), .cop_addr(cop_addr), .cop_rd(cop_rd),
    .cop_byte(cop_byte), .cop_fetch(cop_fetch),
    .q_adv(q_adv), .q_flush(q_flush),
    .trig_o(trig_o), .brk_o(brk_o), .disarm_o(disarm_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: what the selected bus sees and what it means this cycle.
  task automatic tick();
    bit v, rd, by, fe, hit_i, hit_t, ex, want_t, want_b;
    logic [AW-1:0] a;
    v  = cfg_src ? cop_valid : cpu_valid;
    a  = cfg_src ? cop_addr  : cpu_addr;
    rd = cfg_src ? cop_rd    : cpu_rd;
    by = cfg_src ? cop_byte  : cpu_byte;
    fe = cfg_src ? cop_fetch : cpu_fetch;
    hit_i = 0; hit_t = 0;
    if (cfg_en && v && a == cfg_addr) begin
      if (cfg_tag) hit_t = fe && q_adv;
      else hit_i = (cfg_rwe ? (rd == cfg_rw) : 1'b1) && (cfg_sze ? (by == cfg_sz) : 1'b1);
    end
    ex = cfg_en && cfg_tag && q_adv && !q_flush && mq[DEPTH-1];
    want_t = hit_i || ex;
    want_b = want_t && cfg_brk && (brk_gen_en != 0);
    @(posedge clk);
    if (q_flush) begin
      foreach (mq[i]) mq[i] = 0;
    end else if (q_adv) begin
      void'(mq.pop_back());
      mq.push_front(hit_t);
    end
    @(negedge clk);
    chk(trig_o == want_t, cur_req, trig_o, want_t);
    chk(brk_o == want_b && disarm_o == want_b, "R9", {brk_o, disarm_o}, {want_b, want_b});
    if (trig_o) saw_trig = 1;
  endtask

  task automatic idle_bus();
    cpu_valid = 0; cpu_addr = '0; cpu_rd = 0; cpu_byte = 0; cpu_fetch = 0;
    cop_valid = 0; cop_addr = '0; cop_rd = 0; cop_byte = 0; cop_fetch = 0;
    q_adv = 0; q_flush = 0;
  endtask

  task automatic drive(input bit cop, input logic [AW-1:0] a, input bit rd,
                       input bit by, input bit fe);
    idle_bus();
    if (cop) begin cop_valid = 1; cop_addr = a; cop_rd = rd; cop_byte = by; cop_fetch = fe; end
    else     begin cpu_valid = 1; cpu_addr = a; cpu_rd = rd; cpu_byte = by; cpu_fetch = fe; end
  endtask

  task automatic set_cfg(input bit en, input bit src, input bit tg, input bit bk,
                         input bit rwe, input bit rw, input bit sze, input bit sz);
    cfg_en = en; cfg_src = src; cfg_tag = tg; cfg_brk = bk;
    cfg_rwe = rwe; cfg_rw = rw; cfg_sze = sze; cfg_sz = sz;
  endtask

  localparam logic [AW-1:0] MA = 23'h5A_3C71;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    set_cfg(0,0,0,0,0,0,0,0);
    cfg_addr = MA; brk_gen_en = 2'b00;
    idle_bus();
    for (int i = 0; i < DEPTH; i++) mq.push_back(0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(trig_o == 0 && brk_o == 0 && disarm_o == 0, "R10", {trig_o, brk_o, disarm_o}, 0);

    // R1: disabled channel, matching access
    cur_req = "R1";
    set_cfg(0,0,0,1,0,0,0,0); brk_gen_en = 2'b01;
    drive(0, MA, 1, 0, 1); q_adv = 1; tick();
    chk(trig_o == 0, "R1", trig_o, 0);

    // R3 / R10: immediate match gives one-cycle pulse; neighbour address misses
    cur_req = "R3";
    set_cfg(1,0,0,0,0,0,0,0);
    drive(0, MA, 0, 0, 0); tick();
    chk(trig_o == 1, "R3", trig_o, 1);
    idle_bus(); tick();
    chk(trig_o == 0, "R10", trig_o, 1'b0);
    drive(0, MA ^ 23'h40_0000, 0, 0, 0); tick();
    chk(trig_o == 0, "R3", trig_o, 0);

    // R2: bus select
    cur_req = "R2";
    set_cfg(1,1,0,0,0,0,0,0);
    drive(0, MA, 0, 0, 0); tick();
    chk(trig_o == 0, "R2", trig_o, 0);
    drive(1, MA, 0, 0, 0); tick();
    chk(trig_o == 1, "R2", trig_o, 1);

    // R4: direction truth table
    cur_req = "R4";
    for (int m = 0; m < 8; m++) begin
      set_cfg(1,0,0,0, m[2], m[1], 0, 0);
      drive(0, MA, m[0], 0, 0); tick();
    end

    // R5: size truth table
    cur_req = "R5";
    for (int m = 0; m < 8; m++) begin
      set_cfg(1,0,0,0, 0, 0, m[2], m[1]);
      drive(0, MA, 0, m[0], 0); tick();
    end

    // R9: break permission
    cur_req = "R9";
    for (int g = 0; g < 4; g++) begin
      brk_gen_en = g[1:0];
      set_cfg(1,0,0,1,0,0,0,0);
      drive(0, MA, 0, 0, 0); tick();
      chk(brk_o == (g != 0), "R9", brk_o, g != 0);
    end
    set_cfg(1,0,0,0,0,0,0,0); drive(0, MA, 0, 0, 0); tick();
    chk(brk_o == 0, "R9", brk_o, 0);
    brk_gen_en = 2'b10;

    // R6: tagged mode ignores direction/size and needs a fetch
    cur_req = "R6";
    set_cfg(1,0,1,1,1,1,1,1);
    drive(0, MA, 0, 0, 0); q_adv = 1; tick();
    chk(trig_o == 0, "R6", trig_o, 0);
    for (int k = 0; k < DEPTH; k++) begin idle_bus(); q_adv = 1; tick(); end

    // R7: tagged fetch (wrong dir/size) triggers on the DEPTH-th advance, stalls hold it
    cur_req = "R7";
    drive(0, MA, 0, 0, 1); q_adv = 1; tick();
    saw_trig = 0;
    for (int k = 1; k < DEPTH; k++) begin
      idle_bus(); tick();
      idle_bus(); q_adv = 1; tick();
    end
    chk(saw_trig == 0, "R7", saw_trig, 0);
    idle_bus(); q_adv = 1; tick();
    chk(trig_o == 1, "R7", trig_o, 1);

    // R8: flush discards the tag
    cur_req = "R8";
    saw_trig = 0;
    drive(0, MA, 1, 1, 1); q_adv = 1; tick();
    idle_bus(); q_adv = 1; tick();
    idle_bus(); q_adv = 1; q_flush = 1; tick();
    for (int k = 0; k < DEPTH + 1; k++) begin idle_bus(); q_adv = 1; tick(); end
    chk(saw_trig == 0, "R8", saw_trig, 0);

    // R1: tag in flight, disabled when it executes
    cur_req = "R1";
    drive(0, MA, 1, 0, 1); q_adv = 1; tick();
    cfg_en = 0;
    for (int k = 0; k < DEPTH; k++) begin idle_bus(); q_adv = 1; tick(); end
    chk(trig_o == 0, "R1", trig_o, 0);

    // Random mix against the model
    cur_req = "R6";
    for (int n = 0; n < 3000; n++) begin
      set_cfg(($urandom % 8) != 0, $urandom, $urandom, $urandom,
              $urandom, $urandom, $urandom, $urandom);
      brk_gen_en = $urandom;
      cpu_valid = $urandom; cpu_rd = $urandom; cpu_byte = $urandom; cpu_fetch = $urandom;
      cop_valid = $urandom; cop_rd = $urandom; cop_byte = $urandom; cop_fetch = $urandom;
      cpu_addr = ($urandom % 3 != 0) ? MA : MA ^ (23'd1 << ($urandom % AW));
      cop_addr = ($urandom % 3 != 0) ? MA : MA ^ (23'd1 << ($urandom % AW));
      q_adv = ($urandom % 4) != 0;
      q_flush = ($urandom % 16) == 0;
      if (n % 50 == 0) cfg_tag = cfg_tag;
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule